// File: doc/BRIEF.md
# Per-Thread Pause Counter Unit

This block gives each hardware thread of a multithreaded core a pause facility. When software writes a cycle count for a thread, that thread is held off: a stall output goes high and stays high for about the requested number of cycles. The wait is counted in blocks of eight clock cycles. A request shorter than one block still holds the thread for exactly one cycle. A disrupting trap on a thread ends its pause at once. When a pause ends, whether because its count ran out or because a trap cut it short, the block raises a one-cycle done pulse.

Every thread has its own lane, made from a small state machine and a 3-bit prescaler. The lanes share nothing except the clock and the reset.

The states of each lane are:
- `PS_IDLE`: no pause is active.
- `PS_SHORT`: a one-cycle block for a request below eight.
- `PS_COUNT`: a block counted in groups of eight cycles.

The transitions are:
- IDLE to SHORT, and IDLE to COUNT, on a write.
- SHORT to IDLE after one cycle.
- COUNT to IDLE when the group counter expires.
- SHORT or COUNT to IDLE on a trap.
- SHORT or COUNT back into SHORT or COUNT on a reload write.

Top module: `pause_unit`

## Requirements
- R1: A write of value v ≥ 8 holds stall high for exactly (v >> 3) × 8 cycles, so bits [2:0] of the value are dropped. When the pause runs out on its own, stall falls in the cycle in which the group counter reaches zero.
- R2: A write of a value below 8, including 0, holds stall high for exactly one cycle.
- R3: Stall rises in the first cycle after the cycle in which the write strobe is sampled.
- R4: When a pause runs out on its own, done is high for exactly one cycle: the first cycle in which stall is low again.
- R5: A trap sampled while stall is high makes stall low in the next cycle, and done is high in that same cycle.
- R6: A trap sampled while the lane is idle and no write is present has no effect: stall and done both stay low.
- R7: If a trap and a write are sampled in the same cycle while stall is high, the trap wins and the write is ignored.
- R8: A write during an active pause reloads the count and restarts the prescaler. Stall then lasts for the new value, measured from that write, and no done pulse is raised at the reload.
- R9: The lanes are independent. A write or trap on one thread does not change the stall or done output of any other thread.
- R10: While reset is asserted, and in the first cycle after it, every stall and done output is low. This holds even if a pause was active when reset was applied.
- R11: A trap and a write sampled together while the lane is idle start the pause as if only the write had been present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | N_THREADS | Per-thread write strobe for the pause count |
| wr_data | input | N_THREADS*DATA_W | Per-thread pause count. Thread t uses bits [t*DATA_W +: DATA_W] |
| trap | input | N_THREADS | Per-thread disrupting-trap pulse |
| stall | output | N_THREADS | Per-thread stall; high while the thread is paused |
| done | output | N_THREADS | Per-thread one-cycle pulse raised when a pause ends |

## Verification
The bench builds the unit with N_THREADS = 2 and DATA_W = 8, keeping SHIFT at 3. With an 8-bit count, the longest pause is 248 cycles, so the bench can time every pause in full. This covers the largest count (255), the boundary values 7, 8, 15 and 16, and a pause at the all-ones limit. With two lanes, the bench can also show that a trap on one thread leaves a pause on the other thread running to its full length.

// File: rtl/pause_pkg.sv
package pause_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_SHORT = 2'd1,
        PS_COUNT = 2'd2
    } pause_state_e;

endpackage

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic wrap
);
    localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign wrap = run && !clr && (pre_q == PRE_MAX);
endmodule

// File: rtl/pause_thread.sv
module pause_thread
    import pause_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SHIFT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trap,
    output logic              stall,
    output logic              done
);
    localparam int CNT_W = DATA_W - SHIFT;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    pause_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_d;
    logic             group_wrap;
    logic             active;
    logic [CNT_W-1:0] load_val;

    assign active   = (state_q != PS_IDLE);
    assign load_val = wr_data[DATA_W-1:SHIFT];

    pause_prescaler #(.PRE_W(SHIFT)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  ((state_q != PS_COUNT) || wr_en),
        .run  (state_q == PS_COUNT),
        .wrap (group_wrap)
    );

    // next-state and next-count decode
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        if (trap && active) begin
            state_d = PS_IDLE;
            cnt_d   = '0;
            done_d  = 1'b1;
        end else if (wr_en) begin
            cnt_d   = load_val;
            state_d = (load_val == '0) ? PS_SHORT : PS_COUNT;
        end else begin
            unique case (state_q)
                PS_IDLE: begin
                    state_d = PS_IDLE;
                end
                PS_SHORT: begin
                    state_d = PS_IDLE;
                    done_d  = 1'b1;
                end
                PS_COUNT: begin
                    if (group_wrap) begin
                        cnt_d = cnt_q - 1'b1;
                        if (cnt_q == CNT_ONE) begin
                            state_d = PS_IDLE;
                            done_d  = 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = PS_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output and counter registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            done  <= done_d;
        end
    end

    assign stall = active;
endmodule

// File: rtl/pause_unit.sv
module pause_unit #(
    parameter int N_THREADS = 4,
    parameter int DATA_W    = 16,
    parameter int SHIFT     = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_THREADS-1:0]          wr_en,
    input  logic [N_THREADS*DATA_W-1:0]   wr_data,
    input  logic [N_THREADS-1:0]          trap,
    output logic [N_THREADS-1:0]          stall,
    output logic [N_THREADS-1:0]          done
);
    for (genvar t = 0; t < N_THREADS; t++) begin : g_lane
        pause_thread #(
            .DATA_W (DATA_W),
            .SHIFT  (SHIFT)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en[t]),
            .wr_data (wr_data[t*DATA_W +: DATA_W]),
            .trap    (trap[t]),
            .stall   (stall[t]),
            .done    (done[t])
        );
    end
endmodule

// File: rtl/pause_unit_chk.sv
module pause_unit_chk #(
    parameter int N_THREADS = 4,
    parameter int DATA_W    = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic [N_THREADS-1:0]        wr_en,
    input logic [N_THREADS*DATA_W-1:0] wr_data,
    input logic [N_THREADS-1:0]        trap,
    input logic [N_THREADS-1:0]        stall,
    input logic [N_THREADS-1:0]        done
);
    for (genvar t = 0; t < N_THREADS; t++) begin : g_chk
        p_stall_after_write_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_en[t] && !(trap[t] && stall[t])) |=> stall[t]);

        p_trap_abort_r5: assert property (@(posedge clk) disable iff (rst)
            (trap[t] && stall[t]) |=> (!stall[t] && done[t]));

        p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
            done[t] |=> !done[t]);

        p_done_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
            done[t] |-> ($past(stall[t]) && !stall[t]));

        p_idle_trap_r6: assert property (@(posedge clk) disable iff (rst)
            (trap[t] && !stall[t] && !wr_en[t]) |=> (!stall[t] && !done[t]));

        p_short_r2: assert property (@(posedge clk) disable iff (rst)
            (wr_en[t] && !stall[t] && (wr_data[t*DATA_W +: DATA_W] < DATA_W'(8)))
            |=> (stall[t] ##1 (!stall[t] || $past(wr_en[t]))));
    end
endmodule

bind pause_unit pause_unit_chk #(
    .N_THREADS (N_THREADS),
    .DATA_W    (DATA_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .trap    (trap),
    .stall   (stall),
    .done    (done)
);

// File: tb/pause_unit_tb_top.sv
`timescale 1ns/1ps
module pause_unit_tb_top;
    localparam int NT = 2;
    localparam int DW = 8;
    localparam int NV = 9;
    localparam int VEC_VAL [NV] = '{8, 15, 16, 24, 100, 255, 0, 7, 1};
    localparam int VEC_LEN [NV] = '{8,  8, 16, 24,  96, 248, 1, 1, 1};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NT-1:0]      wr_en = '0;
    logic [NT*DW-1:0]   wr_data = '0;
    logic [NT-1:0]      trap = '0;
    logic [NT-1:0]      stall;
    logic [NT-1:0]      done;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pause_unit #(.N_THREADS(NT), .DATA_W(DW), .SHIFT(3)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .trap(trap), .stall(stall), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // strobe a write on one thread; returns at the first negedge after it
    task automatic do_write(input int th, input int val);
        @(negedge clk);
        wr_en[th] = 1'b1;
        wr_data[th*DW +: DW] = DW'(val);
        @(negedge clk);
        wr_en[th] = 1'b0;
    endtask

    // count stall cycles from current negedge; ends at the first low sample
    task automatic count_stall(input int th, output int len);
        len = 0;
        while (stall[th] && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int len;
        int l0;
        int l1;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 stall in reset", int'(stall), 0);
        chk("R10 done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 stall after reset", int'(stall), 0);

        // vector table: R1 / R2 / R3 / R4
        for (int i = 0; i < NV; i++) begin
            do_write(0, VEC_VAL[i]);
            chk("R3 stall rises after write", int'(stall[0]), 1);
            count_stall(0, len);
            if (VEC_VAL[i] < 8) chk("R2 short pause length", len, VEC_LEN[i]);
            else                chk("R1 pause length", len, VEC_LEN[i]);
            chk("R4 done at end", int'(done[0]), 1);
            @(negedge clk);
            chk("R4 done single cycle", int'(done[0]), 0);
            repeat (2) @(negedge clk);
        end

        // R5: trap mid pause
        do_write(0, 80);
        repeat (19) @(negedge clk);
        trap[0] = 1'b1;
        @(negedge clk);
        trap[0] = 1'b0;
        chk("R5 stall dropped by trap", int'(stall[0]), 0);
        chk("R5 done on trap", int'(done[0]), 1);
        @(negedge clk);
        chk("R5 done single cycle", int'(done[0]), 0);

        // R6: trap while idle
        trap[0] = 1'b1;
        @(negedge clk);
        trap[0] = 1'b0;
        chk("R6 idle trap stall", int'(stall[0]), 0);
        chk("R6 idle trap done", int'(done[0]), 0);
        @(negedge clk);
        chk("R6 idle trap done later", int'(done[0]), 0);

        // R7: trap and write together while paused
        do_write(0, 80);
        repeat (4) @(negedge clk);
        trap[0] = 1'b1;
        wr_en[0] = 1'b1;
        wr_data[0 +: DW] = DW'(200);
        @(negedge clk);
        trap[0] = 1'b0;
        wr_en[0] = 1'b0;
        chk("R7 trap wins stall", int'(stall[0]), 0);
        chk("R7 trap wins done", int'(done[0]), 1);
        repeat (3) @(negedge clk);
        chk("R7 write ignored", int'(stall[0]), 0);

        // R11: trap and write together while idle
        @(negedge clk);
        trap[0] = 1'b1;
        wr_en[0] = 1'b1;
        wr_data[0 +: DW] = DW'(16);
        @(negedge clk);
        trap[0] = 1'b0;
        wr_en[0] = 1'b0;
        count_stall(0, len);
        chk("R11 idle trap+write length", len, 16);
        repeat (2) @(negedge clk);

        // R8: reload during pause
        do_write(0, 80);
        repeat (9) @(negedge clk);
        wr_en[0] = 1'b1;
        wr_data[0 +: DW] = DW'(16);
        @(negedge clk);
        wr_en[0] = 1'b0;
        chk("R8 no done at reload", int'(done[0]), 0);
        count_stall(0, len);
        chk("R8 reloaded length", len, 16);
        repeat (2) @(negedge clk);

        // R9: independent lanes
        @(negedge clk);
        wr_en = 2'b11;
        wr_data = {DW'(40), DW'(40)};
        @(negedge clk);
        wr_en = 2'b00;
        l0 = 0;
        l1 = 0;
        for (int i = 0; i < 60; i++) begin
            if (stall[0]) l0++;
            if (stall[1]) l1++;
            if (i == 4) trap[1] = 1'b1;
            if (i == 5) trap[1] = 1'b0;
            @(negedge clk);
        end
        chk("R9 lane 0 unaffected", l0, 40);
        chk("R9 lane 1 trapped", l1, 5);

        // R10: reset during an active pause
        do_write(1, 200);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 reset clears stall", int'(stall), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 stays clear after reset", int'(stall | done), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule